// File: doc/BRIEF.md
# Soft-Output Threshold Decoder for the (21,11) Difference-Set Cyclic Code

This block takes one received word of 21 quantized soft symbols and produces, bit by bit, a soft output (a log-likelihood value), the extrinsic part of that value and a hard decision. The code is the cyclic (21,11) code built on the perfect difference set {0,1,4,14,16} modulo 21. Every bit is covered by five parity checks that are orthogonal on it, so the other 20 bits each appear in exactly one of those checks.

For each check the block forms a weight: the smallest magnitude among the four other symbols in the check, signed by the parity of their hard decisions. The five weights are summed and saturated to form the extrinsic value. The soft output is then a programmable channel factor times the bit's own received value, plus the extrinsic value. The word is held in a rotating register, so one bit is decoded per clock. A word takes 22 cycles: one to load and 21 to decode. An outer iterative loop supplies the channel factor and uses the extrinsic stream.

Top module: `thr_app_decoder`

## Requirements
- R1: While reset is held low, and in the first cycle after it, busy, out_valid, out_idx, llr_out, ext_out and dec_out are all zero.
- R2: A start pulse while idle loads word_in and scale on that clock edge. Busy rises after it. Results for bit k appear with out_valid high and out_idx = k after the (k+2)-th edge that counts from the start edge as the first. Bits 0..20 come on 21 consecutive cycles, so a word takes 22 cycles.
- R3: A start pulse while busy is ignored. The running word's results carry on unchanged, with the word and scale that were loaded at its start.
- R4: For bit k, check i (i = 0..4, with D = {0,1,4,14,16}) covers the four symbols at positions (k + D[m] - D[i]) mod 21 for each m ≠ i.
- R5: Symbol j sits at word_in[j*Q_W +: Q_W]. Its MSB is the sign (1 means hard bit 1 and a negative value), and the lower Q_W-1 bits are the magnitude. A check's weight has the magnitude of the minimum among its four symbols. It is negative exactly when the XOR of their sign bits is 1.
- R6: ext_out is the sum of the five weights, saturated to the range [-2^(EXT_W-1), 2^(EXT_W-1)-1].
- R7: llr_out equals scale (unsigned) times the signed value of symbol k, plus ext_out. This is exact, with no saturation.
- R8: dec_out is 1 exactly when llr_out is negative. A zero LLR gives 0.
- R9: Busy falls after the edge that delivers bit 20. A start on the next edge is accepted, so words can follow back to back with one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load a new word when idle |
| word_in | input | 21*Q_W | 21 sign-magnitude soft symbols, symbol j at bits j*Q_W upward |
| scale | input | SCL_W | Unsigned channel factor, latched at start |
| busy | output | 1 | A word is being decoded |
| out_valid | output | 1 | Outputs below hold the result for bit out_idx |
| out_idx | output | 5 | Index of the bit being reported |
| llr_out | output | LLR_W | Signed soft output |
| ext_out | output | EXT_W | Signed, saturated extrinsic value |
| dec_out | output | 1 | Hard decision, 1 when the LLR is negative |

## Verification
The state that matters is the rotation of the symbol register and the bit counter. A rotation that slips by one place makes every check tap the wrong neighbours, so ext_out goes wrong from bit 1 onward, one cycle after the first result. A counter fault shows at once as a gap or a jump in out_idx, or as busy falling early or late. The bench compares every bit of every word against a model built from the difference set, and places single negative symbols so that one check each flips bit 0. A tap error therefore cannot hide behind symmetric data.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int CODE_N = 21;
    localparam int CHK_J  = 5;
    localparam int OTH_M  = CHK_J - 1;

    // perfect difference set modulo CODE_N
    function automatic int dset(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            2:       return 4;
            3:       return 14;
            default: return 16;
        endcase
    endfunction

    // rotation offset of the m-th other symbol of check i
    function automatic int tap_off(input int i, input int m);
        int e;
        e = (m < i) ? m : m + 1;
        return (dset(e) - dset(i) + CODE_N) % CODE_N;
    endfunction
endpackage

// File: rtl/thr_addmin.sv
module thr_addmin #(
    parameter int N_IN  = 4,
    parameter int MAG_W = 4
) (
    input  logic [N_IN*MAG_W-1:0] mag_in,
    input  logic [N_IN-1:0]       hard_in,
    output logic signed [MAG_W:0] w_out
);
    logic [MAG_W-1:0] mn;
    logic             par;

    always_comb begin
        mn = mag_in[MAG_W-1:0];
        for (int k = 1; k < N_IN; k++) begin
            if (mag_in[k*MAG_W +: MAG_W] < mn) mn = mag_in[k*MAG_W +: MAG_W];
        end
        par   = ^hard_in;
        w_out = par ? -$signed({1'b0, mn}) : $signed({1'b0, mn});
    end
endmodule

// File: rtl/thr_sat_sum.sv
module thr_sat_sum #(
    parameter int N_IN  = 5,
    parameter int IN_W  = 5,
    parameter int OUT_W = 7
) (
    input  logic [N_IN*IN_W-1:0]     terms,
    output logic signed [OUT_W-1:0]  sum_out
);
    localparam int RAW_W = IN_W + $clog2(N_IN) + 1;
    localparam int ACC_W = (RAW_W > OUT_W + 1) ? RAW_W : OUT_W + 1;
    localparam logic signed [ACC_W-1:0] HI = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LO = -HI - ACC_W'(1);

    logic signed [ACC_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int k = 0; k < N_IN; k++) begin
            acc = acc + ACC_W'($signed(terms[k*IN_W +: IN_W]));
        end
        if (acc > HI)      sum_out = OUT_W'(HI);
        else if (acc < LO) sum_out = OUT_W'(LO);
        else               sum_out = OUT_W'(acc);
    end
endmodule

// File: rtl/thr_scale.sv
module thr_scale #(
    parameter int MAG_W = 4,
    parameter int SCL_W = 3,
    parameter int PRD_W = MAG_W + SCL_W + 1
) (
    input  logic [MAG_W-1:0]        mag,
    input  logic                    neg,
    input  logic [SCL_W-1:0]        factor,
    output logic signed [PRD_W-1:0] prod
);
    logic [PRD_W-1:0] part [SCL_W];
    logic [PRD_W-1:0] acc;

    for (genvar g = 0; g < SCL_W; g++) begin : g_pp
        assign part[g] = factor[g] ? (PRD_W'(mag) << g) : '0;
    end

    always_comb begin
        acc = '0;
        for (int g = 0; g < SCL_W; g++) acc = acc + part[g];
        prod = neg ? -$signed(acc) : $signed(acc);
    end
endmodule

// File: rtl/thr_app_decoder.sv
module thr_app_decoder
    import thr_pkg::*;
#(
    parameter int Q_W   = 5,
    parameter int SCL_W = 3,
    parameter int EXT_W = 7,
    localparam int MAG_W = Q_W - 1,
    localparam int W_W   = MAG_W + 1,
    localparam int PRD_W = MAG_W + SCL_W + 1,
    localparam int LLR_W = ((PRD_W > EXT_W) ? PRD_W : EXT_W) + 1,
    localparam int CNT_W = $clog2(CODE_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CODE_N*Q_W-1:0]    word_in,
    input  logic [SCL_W-1:0]         scale,
    output logic                     busy,
    output logic                     out_valid,
    output logic [CNT_W-1:0]         out_idx,
    output logic signed [LLR_W-1:0]  llr_out,
    output logic signed [EXT_W-1:0]  ext_out,
    output logic                     dec_out
);
    typedef logic [Q_W-1:0] sym_t;

    typedef struct packed {
        logic                     busy;
        logic [CNT_W-1:0]         cnt;
        sym_t [CODE_N-1:0]        sbuf;
        logic [SCL_W-1:0]         scl;
        logic                     vld;
        logic [CNT_W-1:0]         idx;
        logic signed [LLR_W-1:0]  llr;
        logic signed [EXT_W-1:0]  ext;
        logic                     dec;
    } dec_state_t;

    dec_state_t r_d, r_q;

    logic [CHK_J*W_W-1:0]      w_flat;
    logic signed [EXT_W-1:0]   ext_w;
    logic signed [PRD_W-1:0]   chan_w;
    logic signed [LLR_W-1:0]   llr_w;

    // the bit under decode always sits at position 0; taps are fixed offsets
    for (genvar i = 0; i < CHK_J; i++) begin : g_chk
        logic [OTH_M*MAG_W-1:0] mags;
        logic [OTH_M-1:0]       hards;
        for (genvar m = 0; m < OTH_M; m++) begin : g_tap
            localparam int P = tap_off(i, m);
            assign mags[m*MAG_W +: MAG_W] = r_q.sbuf[P][MAG_W-1:0];
            assign hards[m]               = r_q.sbuf[P][Q_W-1];
        end
        thr_addmin #(.N_IN(OTH_M), .MAG_W(MAG_W)) u_min (
            .mag_in  (mags),
            .hard_in (hards),
            .w_out   (w_flat[i*W_W +: W_W])
        );
    end

    thr_sat_sum #(.N_IN(CHK_J), .IN_W(W_W), .OUT_W(EXT_W)) u_sum (
        .terms   (w_flat),
        .sum_out (ext_w)
    );

    thr_scale #(.MAG_W(MAG_W), .SCL_W(SCL_W), .PRD_W(PRD_W)) u_scl (
        .mag    (r_q.sbuf[0][MAG_W-1:0]),
        .neg    (r_q.sbuf[0][Q_W-1]),
        .factor (r_q.scl),
        .prod   (chan_w)
    );

    assign llr_w = LLR_W'(chan_w) + LLR_W'(ext_w);

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (!r_q.busy) begin
            if (start) begin
                r_d.busy = 1'b1;
                r_d.cnt  = '0;
                r_d.sbuf = word_in;
                r_d.scl  = scale;
            end
        end else begin
            r_d.vld  = 1'b1;
            r_d.idx  = r_q.cnt;
            r_d.llr  = llr_w;
            r_d.ext  = ext_w;
            r_d.dec  = llr_w[LLR_W-1];
            r_d.sbuf = {r_q.sbuf[0], r_q.sbuf[CODE_N-1:1]};
            r_d.cnt  = r_q.cnt + CNT_W'(1);
            if (r_q.cnt == CNT_W'(CODE_N - 1)) r_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = r_q.busy;
    assign out_valid = r_q.vld;
    assign out_idx   = r_q.idx;
    assign llr_out   = r_q.llr;
    assign ext_out   = r_q.ext;
    assign dec_out   = r_q.dec;

    a_r2_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> out_valid && out_idx == '0);

    a_r2_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) |-> out_idx == CNT_W'($past(out_idx) + CNT_W'(1)));

    a_r2_stream: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> out_valid);

    a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy && out_valid |=> out_valid && out_idx != '0);

    a_r9_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_valid && out_idx == CNT_W'(CODE_N - 1));
endmodule

// File: tb/thr_app_decoder_test.sv
module thr_app_decoder_test;
    localparam int N = 21;
    localparam int Q = 5;
    localparam int SW = 3;
    localparam int EW = 7;
    localparam int LW = 9;
    localparam int DS [5] = '{0, 1, 4, 14, 16};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N*Q-1:0] word_in = '0;
    logic [SW-1:0] scale = '0;
    logic busy, out_valid, dec_out;
    logic [4:0] out_idx;
    logic signed [LW-1:0] llr_out;
    logic signed [EW-1:0] ext_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    thr_app_decoder #(.Q_W(Q), .SCL_W(SW), .EXT_W(EW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in), .scale(scale),
        .busy(busy), .out_valid(out_valid), .out_idx(out_idx),
        .llr_out(llr_out), .ext_out(ext_out), .dec_out(dec_out)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sval(input logic [N*Q-1:0] w, input int j);
        logic [Q-1:0] s;
        s = w[j*Q +: Q];
        return s[Q-1] ? -int'(s[Q-2:0]) : int'(s[Q-2:0]);
    endfunction

    function automatic int ref_ext(input logic [N*Q-1:0] w, input int k);
        int sum = 0;
        for (int i = 0; i < 5; i++) begin
            int mn = 1000;
            int par = 0;
            for (int m = 0; m < 5; m++) begin
                if (m != i) begin
                    int p = (k - DS[i] + DS[m] + 2 * N) % N;
                    logic [Q-1:0] s = w[p*Q +: Q];
                    if (int'(s[Q-2:0]) < mn) mn = int'(s[Q-2:0]);
                    par = par ^ int'(s[Q-1]);
                end
            end
            sum += par ? -mn : mn;
        end
        if (sum > 63) sum = 63;
        if (sum < -64) sum = -64;
        return sum;
    endfunction

    // decode one word; optionally disturb start/word/scale mid-decode
    task automatic run_word(input logic [N*Q-1:0] w, input int scl, input bit disturb, input string tag);
        @(negedge clk);
        check(busy == 1'b0, {"R9 idle before ", tag}, busy, 0);
        start = 1'b1; word_in = w; scale = SW'(scl);
        @(negedge clk);
        start = 1'b0; word_in = ~w; scale = SW'(scl + 3);
        check(busy == 1'b1 && out_valid == 1'b0, {"R2 load ", tag}, busy, 1);
        for (int k = 0; k < N; k++) begin
            int e, l;
            if (disturb && k == 5) start = 1'b1;
            if (disturb && k == 6) start = 1'b0;
            @(negedge clk);
            e = ref_ext(w, k);
            l = scl * sval(w, k) + e;
            check(out_valid == 1'b1 && int'(out_idx) == k, {"R2 index ", tag}, int'(out_idx), k);
            check(int'(ext_out) == e, {"R4/R5/R6 ext ", tag}, int'(ext_out), e);
            check(int'(llr_out) == l, {"R7 llr ", tag, disturb ? " R3" : ""}, int'(llr_out), l);
            check(dec_out == (l < 0), {"R8 dec ", tag}, dec_out, int'(l < 0));
        end
        check(busy == 1'b0, {"R9 busy falls ", tag}, busy, 0);
    endtask

    function automatic logic [N*Q-1:0] fill(input logic [Q-1:0] s);
        logic [N*Q-1:0] w;
        for (int j = 0; j < N; j++) w[j*Q +: Q] = s;
        return w;
    endfunction

    function automatic logic [N*Q-1:0] rand_word(input int seed);
        logic [31:0] x = 32'h1234_5678 ^ seed;
        logic [N*Q-1:0] w;
        for (int j = 0; j < N; j++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            w[j*Q +: Q] = x[Q-1:0];
        end
        return w;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(busy == 0 && out_valid == 0 && out_idx == 0, "R1 reset ctrl", busy, 0);
        check(llr_out == 0 && ext_out == 0 && dec_out == 0, "R1 reset data", int'(llr_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && out_valid == 0, "R1 after release", busy, 0);
    endtask

    task automatic t_zero();
        run_word('0, 5, 1'b0, "zero word");
        check(llr_out == 0 && dec_out == 0, "R8 zero llr gives 0", int'(llr_out), 0);
    endtask

    task automatic t_pos_sat();
        run_word(fill(5'h0F), 7, 1'b0, "pos sat");
        check(int'(ext_out) == 63 && int'(llr_out) == 168, "R6 positive clamp", int'(ext_out), 63);
    endtask

    task automatic t_neg_sat();
        logic [N*Q-1:0] w = fill(5'h0F);
        for (int i = 0; i < 5; i++) begin
            int p = (DS[(i + 1) % 5] - DS[i] + N) % N;
            w[p*Q +: Q] = 5'h1F;
        end
        @(negedge clk);
        start = 1'b1; word_in = w; scale = 3'd1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(int'(ext_out) == -64, "R4/R6 negative clamp bit0", int'(ext_out), -64);
        check(int'(llr_out) == -49 && dec_out == 1'b1, "R7/R8 bit0 llr", int'(llr_out), -49);
        while (busy) @(negedge clk);
        run_word(w, 2, 1'b0, "neg pattern full");
    endtask

    task automatic t_random();
        run_word(rand_word(1), 0, 1'b0, "rand scale0");
        run_word(rand_word(2), 5, 1'b0, "rand scale5");
        run_word(rand_word(3), 7, 1'b0, "rand scale7");
    endtask

    task automatic t_busy_start();
        run_word(rand_word(4), 3, 1'b1, "start while busy");
        @(negedge clk);
        check(out_valid == 1'b0 && busy == 1'b0, "R3 no extra word", out_valid, 0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_zero();
        t_pos_sat();
        t_neg_sat();
        t_random();
        t_busy_start();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule